// File: doc/BRIEF.md
# Rotating ALU with Registered Flags

This block is the arithmetic and logic core of a small 32-bit processor datapath. An operation code and two operands come in. A result and its write strobe leave in the same cycle. The block supports add, subtract, multiply, AND, OR, compare, rotate right, rotate left, increment and decrement. The selection of operand B, from a register or from an immediate, is made upstream. The caller presents whichever value applies.

Five condition bits sit in a register that later branch logic reads: zero, sign, overflow, signed-less and signed-greater. That register loads one clock edge after an enabled, accepted operation. It holds its value at all other times.

Compare runs the subtraction only to set the condition bits and never asks for a write-back. Rotations accept four amounts and no others: 1, a quarter word, half a word and three quarters of a word (1, 8, 16 and 24 at the default width). Any other amount is refused: no write happens, the condition bits keep their value and an error strobe is raised.

Top module: `flagged_alu`

## Requirements
- R1: Opcode 0 (add), 1 (subtract), 8 (increment) and 9 (decrement) return A+B, A-B, A+1 and A-1, each modulo 2^W. Each asserts `res_we_o`. Increment and decrement ignore B.
- R2: Opcode 2 (multiply) returns the low W bits of A*B and asserts `res_we_o`.
- R3: Opcode 3 (AND) and opcode 4 (OR) return the bitwise result, assert `res_we_o` and clear the overflow bit.
- R4: Opcode 5 (compare) never asserts `res_we_o`. It sets the condition bits from A-B.
- R5: Opcode 6 (rotate right) and opcode 7 (rotate left) rotate A by B when B is exactly 1, W/4, W/2 or 3W/4, and assert `res_we_o`.
- R6: A rotate with any other B value drives `res_o` = A, keeps `res_we_o` low, raises `rot_err_o` and leaves the condition bits unchanged.
- R7: The overflow bit follows signed two's-complement overflow for add, subtract, increment, decrement and compare. Multiply and rotates clear it.
- R8: `flags_o` is {zero, sign, overflow, less, greater}, with zero at bit 4 and greater at bit 0. Zero and sign come from the result, or from the difference for compare. The bits appear after the first rising clock edge that follows an enabled operation.
- R9: Less and greater are signed comparisons of A with the effective second operand, which is B, or 1 for increment and decrement. Both are low when the two are equal.
- R10: With `en_i` low, the condition bits hold and `res_we_o` is low. Opcodes 10 to 15 drive `res_o` = 0 and `res_we_o` = 0, and leave the condition bits unchanged.
- R11: An active-low `rst_n` clears all condition bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Operation valid this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second operand or rotate amount |
| res_o | output | W | Combinational result |
| res_we_o | output | 1 | Result should be written back |
| rot_err_o | output | 1 | Refused rotate amount |
| flags_o | output | 5 | Registered {zero, sign, overflow, less, greater} |

## Verification
The properties assume that `en_i`, `op_i` and both operands are settled before each rising edge. They also assume that the result strobes are only meaningful while `en_i` is high. Several properties compare flag values after the edge with the operands that were present on that edge. The stimulus therefore changes inputs only on the falling edge and holds them steady across the following rising edge. The vector table keeps `en_i` high. The directed cases lower it only to exercise the hold behaviour. Undefined opcodes and refused rotate amounts reach the block only in the directed cases, so the expected hold of the condition bits can be checked at the outputs.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_MUL = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_CMP = 4'd5,
        OP_ROR = 4'd6,
        OP_ROL = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic zero;
        logic sign;
        logic ovf;
        logic less;
        logic greater;
    } cond_t;

    localparam int NUM_ROT_AMTS = 4;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] y_eff;
    logic [W-1:0] sum;

    always_comb begin
        y_eff = sub_i ? ~y_i : y_i;
        sum   = x_i + y_eff + {{(W-1){1'b0}}, sub_i};
    end

    // Signed overflow: both inputs to the adder share a sign that the sum lacks.
    assign sum_o = sum;
    assign ovf_o = (x_i[MSB] == y_eff[MSB]) && (sum[MSB] != x_i[MSB]);

endmodule

// File: rtl/alu_rotate.sv
module alu_rotate
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] amt_i,
    input  logic         left_i,
    output logic [W-1:0] rot_o,
    output logic         legal_o
);
    logic [NUM_ROT_AMTS-1:0] hit;
    logic [W-1:0]            rr [NUM_ROT_AMTS];
    logic [W-1:0]            rl [NUM_ROT_AMTS];

    for (genvar g = 0; g < NUM_ROT_AMTS; g++) begin : g_amt
        localparam int K = (g == 0) ? 1 : (g * W / NUM_ROT_AMTS);
        assign hit[g] = (amt_i == W'(K));
        assign rr[g]  = (val_i >> K) | (val_i << (W - K));
        assign rl[g]  = (val_i << K) | (val_i >> (W - K));
    end

    always_comb begin
        rot_o   = val_i;
        legal_o = 1'b0;
        for (int i = 0; i < NUM_ROT_AMTS; i++) begin
            if (hit[i]) begin
                rot_o   = left_i ? rl[i] : rr[i];
                legal_o = 1'b1;
            end
        end
    end

    // R5: the permitted amounts are distinct, so at most one candidate matches
    always_comb begin
        p_single_amt_r5: assert ($onehot0(hit) || $isunknown(amt_i));
    end

endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         res_we_o,
    output logic         rot_err_o,
    output logic [4:0]   flags_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    localparam int           MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         we;
        logic         err;
        logic         upd;
        logic         ovf;
    } step_t;

    alu_op_e      op;
    logic [W-1:0] b_eff;
    logic         use_sub;
    logic [W-1:0] sum;
    logic         sum_ovf;
    logic [W-1:0] diff;
    logic         diff_ovf;
    logic [W-1:0] rot_res;
    logic         rot_legal;
    logic [W-1:0] prod;
    logic         lt_s;
    logic         gt_s;
    step_t        st_d;
    cond_t        flags_d;
    cond_t        flags_q;

    assign op = alu_op_e'(op_i);

    always_comb begin
        b_eff   = (op == OP_INC || op == OP_DEC) ? ONE : b_i;
        use_sub = (op == OP_SUB) || (op == OP_DEC) || (op == OP_CMP);
        prod    = a_i * b_i;
    end

    alu_addsub #(.W(W)) i_main_add (
        .x_i   (a_i),
        .y_i   (b_eff),
        .sub_i (use_sub),
        .sum_o (sum),
        .ovf_o (sum_ovf)
    );

    alu_addsub #(.W(W)) i_cmp_sub (
        .x_i   (a_i),
        .y_i   (b_eff),
        .sub_i (1'b1),
        .sum_o (diff),
        .ovf_o (diff_ovf)
    );

    alu_rotate #(.W(W)) i_rot (
        .val_i   (a_i),
        .amt_i   (b_i),
        .left_i  (op == OP_ROL),
        .rot_o   (rot_res),
        .legal_o (rot_legal)
    );

    always_comb begin
        lt_s = diff[MSB] ^ diff_ovf;
        gt_s = !lt_s && (diff != '0);
    end

    always_comb begin
        st_d = '0;
        unique case (op)
            OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
                st_d.res = sum;
                st_d.we  = 1'b1;
                st_d.upd = 1'b1;
                st_d.ovf = sum_ovf;
            end
            OP_MUL: begin
                st_d.res = prod;
                st_d.we  = 1'b1;
                st_d.upd = 1'b1;
            end
            OP_AND: begin
                st_d.res = a_i & b_i;
                st_d.we  = 1'b1;
                st_d.upd = 1'b1;
            end
            OP_OR: begin
                st_d.res = a_i | b_i;
                st_d.we  = 1'b1;
                st_d.upd = 1'b1;
            end
            OP_CMP: begin
                st_d.res = sum;
                st_d.upd = 1'b1;
                st_d.ovf = sum_ovf;
            end
            OP_ROR, OP_ROL: begin
                st_d.res = rot_res;
                st_d.we  = rot_legal;
                st_d.upd = rot_legal;
                st_d.err = !rot_legal;
            end
            default: st_d = '0;
        endcase

        flags_d = flags_q;
        if (en_i && st_d.upd) begin
            flags_d.zero    = (st_d.res == '0);
            flags_d.sign    = st_d.res[MSB];
            flags_d.ovf     = st_d.ovf;
            flags_d.less    = lt_s;
            flags_d.greater = gt_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign res_o     = st_d.res;
    assign res_we_o  = en_i & st_d.we;
    assign rot_err_o = en_i & st_d.err;
    assign flags_o   = flags_q;

    // R4: compare never requests a write
    p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_CMP) |-> !res_we_o);

    // R4: equal operands on compare set zero on the next edge
    p_cmp_equal_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_CMP && a_i == b_i) |=> (flags_o[4] && !flags_o[1] && !flags_o[0]));

    // R6: refused rotate passes A through without a write
    p_rot_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rot_err_o |-> (!res_we_o && res_o == a_i));

    // R6: refused rotate leaves the condition bits alone
    p_rot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rot_err_o |=> $stable(flags_o));

    // R10: idle cycles hold the condition bits
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(flags_o));

    // R3: logic operations leave overflow clear
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (op_i == OP_AND || op_i == OP_OR)) |=> !flags_o[2]);

    // R9: less and greater are never both set
    p_lt_gt_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags_o[1] && flags_o[0]));

endmodule

// File: tb/test_flagged_alu.sv
`timescale 1ns/1ps
module test_flagged_alu;

    localparam int W = 32;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        we;
        logic [4:0]  fl;
    } vec_t;

    // flags {zero, sign, ovf, less, greater}
    localparam vec_t VECS [22] = '{
        '{4'd0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b1, 5'b00010}, // R1
        '{4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b1, 5'b01101}, // R7
        '{4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 5'b10010}, // R8
        '{4'd1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 1'b1, 5'b01010}, // R1
        '{4'd1, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1, 5'b00110}, // R7
        '{4'd2, 32'h0001_0000, 32'h0001_0000, 32'h0000_0000, 1'b1, 5'b10000}, // R2
        '{4'd2, 32'hFFFF_FFFF, 32'h0000_0003, 32'hFFFF_FFFD, 1'b1, 5'b01010}, // R2
        '{4'd3, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, 1'b1, 5'b01010}, // R3
        '{4'd4, 32'h1234_0000, 32'h0000_5678, 32'h1234_5678, 1'b1, 5'b00001}, // R3
        '{4'd5, 32'h0000_0009, 32'h0000_0009, 32'h0000_0000, 1'b0, 5'b10000}, // R4
        '{4'd5, 32'h0000_0002, 32'h0000_0009, 32'h0000_0000, 1'b0, 5'b01010}, // R4
        '{4'd5, 32'h8000_0000, 32'h0000_0001, 32'h0000_0000, 1'b0, 5'b00110}, // R4
        '{4'd6, 32'h1234_5678, 32'h0000_0008, 32'h7812_3456, 1'b1, 5'b00001}, // R5
        '{4'd7, 32'h1234_5678, 32'h0000_0008, 32'h3456_7812, 1'b1, 5'b00001}, // R5
        '{4'd6, 32'h0000_0001, 32'h0000_0001, 32'h8000_0000, 1'b1, 5'b01000}, // R5
        '{4'd7, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 1'b1, 5'b00010}, // R5
        '{4'd6, 32'h1234_5678, 32'h0000_0010, 32'h5678_1234, 1'b1, 5'b00001}, // R5
        '{4'd7, 32'h1234_5678, 32'h0000_0018, 32'h7812_3456, 1'b1, 5'b00001}, // R5
        '{4'd8, 32'h7FFF_FFFF, 32'h0000_0055, 32'h8000_0000, 1'b1, 5'b01101}, // R9
        '{4'd9, 32'h8000_0000, 32'h0000_0055, 32'h7FFF_FFFF, 1'b1, 5'b00110}, // R7
        '{4'd9, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 1'b1, 5'b10000}, // R9
        '{4'd3, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b1, 5'b10010}  // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [31:0] res_o;
    logic        res_we_o;
    logic        rot_err_o;
    logic [4:0]  flags_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    flagged_alu #(.W(W)) i_flagged_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .op_i      (op_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .res_o     (res_o),
        .res_we_o  (res_we_o),
        .rot_err_o (rot_err_o),
        .flags_o   (flags_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive on falling edge, check combinational outputs, then flags after the rising edge
    task automatic apply(input logic en, input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b);
        @(negedge clk);
        en_i = en; op_i = op; a_i = a; b_i = b;
        #1;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [4:0] held;
        repeat (3) @(negedge clk);
        chk("R11 flags in reset", 32'(flags_o), 32'h0);
        rst_n = 1'b1;
        after_edge();
        chk("R11 flags after reset", 32'(flags_o), 32'h0);

        for (int i = 0; i < 22; i++) begin
            apply(1'b1, VECS[i].op, VECS[i].a, VECS[i].b);
            chk($sformatf("R1/R2/R3/R5 we vec%0d", i), 32'(res_we_o), 32'(VECS[i].we));
            chk($sformatf("R6 err low vec%0d", i), 32'(rot_err_o), 32'h0);
            if (VECS[i].we) chk($sformatf("R1/R2/R3/R5 result vec%0d", i), res_o, VECS[i].res);
            after_edge();
            chk($sformatf("R7/R8/R9 flags vec%0d", i), 32'(flags_o), 32'(VECS[i].fl));
        end
        held = flags_o; // 5'b10010

        // R10: idle cycle with an operation that would change flags
        apply(1'b0, 4'd0, 32'h0000_0003, 32'h0000_0004);
        chk("R10 we low when idle", 32'(res_we_o), 32'h0);
        after_edge();
        chk("R10 flags hold when idle", 32'(flags_o), 32'(held));

        // R10: undefined opcode
        apply(1'b1, 4'd15, 32'h1234_5678, 32'h0000_0001);
        chk("R10 undefined result", res_o, 32'h0);
        chk("R10 undefined we", 32'(res_we_o), 32'h0);
        after_edge();
        chk("R10 undefined flags hold", 32'(flags_o), 32'(held));

        // R6: refused rotate amounts
        apply(1'b1, 4'd6, 32'h8765_4321, 32'h0000_0002);
        chk("R6 ror refused err", 32'(rot_err_o), 32'h1);
        chk("R6 ror refused we", 32'(res_we_o), 32'h0);
        chk("R6 ror refused passes A", res_o, 32'h8765_4321);
        after_edge();
        chk("R6 ror refused flags hold", 32'(flags_o), 32'(held));
        apply(1'b1, 4'd7, 32'h8765_4321, 32'h0000_0020);
        chk("R6 rol refused err", 32'(rot_err_o), 32'h1);
        chk("R6 rol refused passes A", res_o, 32'h8765_4321);
        after_edge();
        chk("R6 rol refused flags hold", 32'(flags_o), 32'(held));

        // R7: rotate clears a set overflow; R1 increment wraps to zero
        apply(1'b1, 4'd0, 32'h7FFF_FFFF, 32'h0000_0001);
        after_edge();
        chk("R7 overflow set", 32'(flags_o[2]), 32'h1);
        apply(1'b1, 4'd6, 32'h0000_0100, 32'h0000_0008);
        chk("R5 ror small", res_o, 32'h0000_0001);
        after_edge();
        chk("R7 rotate clears overflow", 32'(flags_o), 32'b00001);
        apply(1'b1, 4'd8, 32'hFFFF_FFFF, 32'h0000_0000);
        chk("R1 inc wraps", res_o, 32'h0);
        after_edge();
        chk("R8 inc zero flag", 32'(flags_o), 32'b10010);

        // R11: reset mid-run
        @(negedge clk);
        en_i = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R11 async clear", 32'(flags_o), 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule